// File: doc/BRIEF.md
# Postal Code Format Recognizer

This block is a streaming acceptor that decides whether a character string has the shape of a short postal code. The code is a run of decimal digits, then a single space, then a run of uppercase letters. With the default parameters that is four digits, one space and two letters, for example `1234 AB`. Characters arrive one per accepted beat on an 8-bit ASCII input stream. Two sideband bits travel with each beat: one marks the first character of a string and the other marks the last. The block checks only the shape of the string. It does not convert the code to a number and does not look it up anywhere.

Inside, the block works through the string in phases. In the number phase only digits are legal. In the gap phase only the space is legal. In the letter phase only uppercase letters are legal. A tail phase is reached after the last letter, and any further character there is an error. Once an error is found, a sticky fault phase holds until the next start-of-string, and every character in between is ignored. The block gives no output per character. On the cycle after the end-of-string beat it raises a one-cycle verdict together with an accept bit.

The input follows valid/ready rules. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during the cycle in which a verdict is presented. A source that offers a beat in that cycle must hold the beat, unchanged, until the next cycle. The verdict output has no back-pressure: the consumer must capture it in the cycle it appears.

Top module: `pc_format_recognizer`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `result_valid` and `result_accept` are 0 and `in_ready` is 1. The block waits for a start-of-string.
- R2: For a string of exactly DIGITS characters in 0x30..0x39, then 0x20, then LETTERS characters in 0x41..0x5A, `result_valid` is 1 for exactly one cycle, the cycle after the end-of-string beat, with `result_accept` = 1.
- R3: Any character outside 0x30..0x39 in one of the first DIGITS positions makes the verdict a reject (`result_accept` = 0). This includes 0x2F and 0x3A.
- R4: The character at position DIGITS+1 must be 0x20. Any other value there gives a reject.
- R5: Only 0x41..0x5A count as letters. Lowercase letters, digits, 0x40 and 0x5B in the letter positions give a reject.
- R6: A string whose end-of-string beat comes before the last letter gives a reject. This includes a one-character string that has both markers on the same beat.
- R7: A string with any character after the last letter gives a reject.
- R8: After an error, later characters of the same string have no effect: the verdict is a reject even if a legal-looking sequence follows.
- R9: A beat with the start-of-string marker always begins a new string and discards any string in progress, whether it was clean or faulty.
- R10: Beats taken while no string is open and without the start-of-string marker are ignored. They produce no verdict, even when they carry the end-of-string marker.
- R11: `in_ready` is 0 in the verdict cycle. A beat offered then is not taken, and it is taken on the next edge if it is still held.
- R12: `result_accept` is 0 whenever `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 8 | ASCII character |
| in_sos | input | 1 | Beat is the first character of a string |
| in_eos | input | 1 | Beat is the last character of a string |
| result_valid | output | 1 | One-cycle verdict strobe |
| result_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The bench builds the block with its default lengths, four digits and two letters, so the seven-character boundary appears directly. Strings of six and eight characters probe one short and one long of that boundary. With these lengths every position class (digit, gap, letter and tail) is visited, and the range edge characters 0x2F, 0x3A, 0x40 and 0x5B can be placed in each class. Back-to-back strings whose next start beat lands in the verdict cycle bring the stall of one beat into view. So do restarts in the middle of a string and stray beats while no string is open.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam logic [7:0] DIGIT_LO  = 8'h30;
  localparam logic [7:0] DIGIT_HI  = 8'h39;
  localparam logic [7:0] UPPER_LO  = 8'h41;
  localparam logic [7:0] UPPER_HI  = 8'h5A;

  typedef enum logic [1:0] {
    CC_DIGIT,
    CC_UPPER,
    CC_SEP,
    CC_OTHER
  } char_class_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_NUMBER,
    PH_GAP,
    PH_LETTER,
    PH_TAIL,
    PH_FAULT
  } phase_e;
endpackage

// File: rtl/pc_char_class.sv
module pc_char_class
  import pc_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  SEP_CHAR = 8'h20
) (
  input  logic [DATA_W-1:0] ch,
  output char_class_e       cls
);
  always_comb begin
    if (ch >= DATA_W'(DIGIT_LO) && ch <= DATA_W'(DIGIT_HI))
      cls = CC_DIGIT;
    else if (ch >= DATA_W'(UPPER_LO) && ch <= DATA_W'(UPPER_HI))
      cls = CC_UPPER;
    else if (ch == DATA_W'(SEP_CHAR))
      cls = CC_SEP;
    else
      cls = CC_OTHER;
  end
endmodule

// File: rtl/pc_pos_counter.sv
module pc_pos_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (clr)
      pos <= CW'(inc);
    else if (inc)
      pos <= pos + CW'(1);
  end
endmodule

// File: rtl/pc_phase_fsm.sv
module pc_phase_fsm
  import pc_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int LETTERS = 2,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          sos,
  input  logic          eos,
  input  char_class_e   cls,
  input  logic [CW-1:0] pos,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          busy,
  output logic          verdict_valid,
  output logic          verdict_ok
);
  localparam logic [CW-1:0] LAST_DIGIT  = CW'(DIGITS - 1);
  localparam logic [CW-1:0] LAST_LETTER = CW'(LETTERS - 1);

  phase_e        cur, eff, settled, nxt;
  logic [CW-1:0] use_pos;
  logic          live;

  always_comb begin
    live    = take && (sos || cur != PH_IDLE);
    eff     = (take && sos) ? PH_NUMBER : cur;
    use_pos = (take && sos) ? '0 : pos;
    settled = cur;
    cnt_clr = take && sos;
    cnt_inc = 1'b0;
    if (live) begin
      case (eff)
        PH_NUMBER: begin
          if (cls != CC_DIGIT) begin
            settled = PH_FAULT;
          end else if (use_pos == LAST_DIGIT) begin
            settled = PH_GAP;
            cnt_clr = 1'b1;
          end else begin
            settled = PH_NUMBER;
            cnt_inc = 1'b1;
          end
        end
        PH_GAP: begin
          if (cls == CC_SEP) begin
            settled = PH_LETTER;
            cnt_clr = 1'b1;
          end else begin
            settled = PH_FAULT;
          end
        end
        PH_LETTER: begin
          if (cls != CC_UPPER) begin
            settled = PH_FAULT;
          end else if (use_pos == LAST_LETTER) begin
            settled = PH_TAIL;
            cnt_clr = 1'b1;
          end else begin
            settled = PH_LETTER;
            cnt_inc = 1'b1;
          end
        end
        default: settled = PH_FAULT;
      endcase
    end
    nxt = (live && eos) ? PH_IDLE : settled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur           <= PH_IDLE;
      verdict_valid <= 1'b0;
      verdict_ok    <= 1'b0;
    end else begin
      cur           <= nxt;
      verdict_valid <= live && eos;
      verdict_ok    <= live && eos && (settled == PH_TAIL);
    end
  end

  assign busy = (cur != PH_IDLE);
endmodule

// File: rtl/pc_format_recognizer.sv
module pc_format_recognizer
  import pc_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         DIGITS   = 4,
  parameter int         LETTERS  = 2,
  parameter logic [7:0] SEP_CHAR = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sos,
  input  logic              in_eos,
  output logic              result_valid,
  output logic              result_accept
);
  localparam int LONGEST = (DIGITS > LETTERS) ? DIGITS : LETTERS;
  localparam int CW      = $clog2(LONGEST + 1);

  char_class_e   cls;
  logic [CW-1:0] pos;
  logic          cnt_clr, cnt_inc, take, str_active;

  assign in_ready = ~result_valid;
  assign take     = in_valid & in_ready;

  pc_char_class #(.DATA_W(DATA_W), .SEP_CHAR(SEP_CHAR)) u_class (
    .ch (in_data),
    .cls(cls)
  );

  pc_pos_counter #(.CW(CW)) u_pos (
    .clk(clk),
    .rst(rst),
    .clr(cnt_clr),
    .inc(cnt_inc),
    .pos(pos)
  );

  pc_phase_fsm #(.DIGITS(DIGITS), .LETTERS(LETTERS), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .sos          (in_sos),
    .eos          (in_eos),
    .cls          (cls),
    .pos          (pos),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .busy         (str_active),
    .verdict_valid(result_valid),
    .verdict_ok   (result_accept)
  );
endmodule

// File: rtl/pc_format_chk.sv
module pc_format_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_sos,
  input logic in_eos,
  input logic result_valid,
  input logic result_accept,
  input logic busy
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!result_valid && in_ready));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R2
  verdict_follows_eos_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(in_valid && in_ready && in_eos));

  // R10
  idle_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_sos && !busy) |=> !result_valid);

  // R12
  accept_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> !result_accept);
endmodule

bind pc_format_recognizer pc_format_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_sos       (in_sos),
  .in_eos       (in_eos),
  .result_valid (result_valid),
  .result_accept(result_accept),
  .busy         (str_active)
);

// File: tb/pc_format_recognizer_bench.sv
module pc_format_recognizer_bench;
  localparam int DIGS = 4;
  localparam int LETS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sos = 1'b0;
  logic       in_eos = 1'b0;
  logic       result_valid;
  logic       result_accept;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #2 clk = ~clk;

  pc_format_recognizer #(.DIGITS(DIGS), .LETTERS(LETS)) u_pc_format_recognizer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sos(in_sos), .in_eos(in_eos),
    .result_valid(result_valid), .result_accept(result_accept)
  );

  // behavioural reference model
  byte  sbuf[$];
  bit   open_str = 1'b0;
  logic exp_rv   = 1'b0;
  logic exp_acc  = 1'b0;
  logic exp_ready;
  assign exp_ready = !exp_rv;

  function automatic bit shape_ok();
    if (sbuf.size() != DIGS + 1 + LETS) return 1'b0;
    for (int i = 0; i < DIGS; i++)
      if (sbuf[i] < "0" || sbuf[i] > "9") return 1'b0;
    if (sbuf[DIGS] != " ") return 1'b0;
    for (int i = DIGS + 1; i < DIGS + 1 + LETS; i++)
      if (sbuf[i] < "A" || sbuf[i] > "Z") return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_rv  <= 1'b0;
      exp_acc <= 1'b0;
      open_str = 1'b0;
      sbuf.delete();
    end else begin
      logic nv, na;
      nv = 1'b0;
      na = 1'b0;
      if (in_valid && exp_ready) begin
        if (in_sos) begin
          sbuf.delete();
          open_str = 1'b1;
        end
        if (open_str) begin
          sbuf.push_back(in_data);
          if (in_eos) begin
            nv = 1'b1;
            na = shape_ok();
            open_str = 1'b0;
          end
        end
      end
      exp_rv  <= nv;
      exp_acc <= na;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "result_valid", result_valid, exp_rv);
      check(cur_req, "result_accept", result_accept, exp_acc);
      check(cur_req, "in_ready", in_ready, exp_ready);
    end
  end

  task automatic put(byte c, bit s, bit e, bit here);
    if (!here) @(negedge clk);
    in_valid = 1'b1;
    in_data  = c;
    in_sos   = s;
    in_eos   = e;
    while (!exp_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sos   = 1'b0;
    in_eos   = 1'b0;
  endtask

  // sends a whole string; returns at the negedge of its verdict cycle
  task automatic send_str(string s, bit acc, string req);
    cur_req = req;
    for (int i = 0; i < s.len(); i++)
      put(s[i], i == 0, i == s.len() - 1, 1'b0);
    idle();
    check(req, "verdict strobe", result_valid, 1'b1);
    check(req, "verdict accept", result_accept, acc);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held quiet during reset
    check("R1", "reset result_valid", result_valid, 1'b0);
    check("R1", "reset in_ready", in_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "post-reset result_valid", result_valid, 1'b0);

    send_str("1234 AB", 1'b1, "R2");
    idle();
    check("R2", "strobe drops after one cycle", result_valid, 1'b0);
    send_str("9087 ZQ", 1'b1, "R2");
    send_str("0000 AZ", 1'b1, "R2");

    send_str("12X4 AB", 1'b0, "R3");
    send_str("/234 AB", 1'b0, "R3");
    send_str("123: AB", 1'b0, "R3");

    send_str("1234-AB", 1'b0, "R4");
    send_str("12345AB", 1'b0, "R4");

    send_str("1234 aB", 1'b0, "R5");
    send_str("1234 A1", 1'b0, "R5");
    send_str("1234 @A", 1'b0, "R5");
    send_str("1234 A[", 1'b0, "R5");

    send_str("1234 A", 1'b0, "R6");
    send_str("1", 1'b0, "R6");
    send_str("1234", 1'b0, "R6");

    send_str("1234 ABC", 1'b0, "R7");
    send_str("1234 AB ", 1'b0, "R7");

    send_str("A1234 AB", 1'b0, "R8");
    send_str("12 1234 AB", 1'b0, "R8");

    // R9: restart mid-string, clean and faulty
    cur_req = "R9";
    put("1", 1'b1, 1'b0, 1'b0);
    put("2", 1'b0, 1'b0, 1'b0);
    send_str("5678 CD", 1'b1, "R9");
    cur_req = "R9";
    put("X", 1'b1, 1'b0, 1'b0);
    send_str("4321 XY", 1'b1, "R9");

    // R10: stray beats with no open string
    idle();
    cur_req = "R10";
    put("1", 1'b0, 1'b0, 1'b0);
    put("2", 1'b0, 1'b1, 1'b0);
    idle();
    check("R10", "no verdict from stray eos", result_valid, 1'b0);
    idle();
    check("R10", "still quiet", result_valid, 1'b0);
    send_str("1111 QQ", 1'b1, "R10");

    // R11: next string offered in the verdict cycle
    cur_req = "R11";
    put("1", 1'b1, 1'b0, 1'b0);
    put("2", 1'b0, 1'b0, 1'b0);
    put("3", 1'b0, 1'b0, 1'b0);
    put("4", 1'b0, 1'b0, 1'b0);
    put(" ", 1'b0, 1'b0, 1'b0);
    put("A", 1'b0, 1'b0, 1'b0);
    put("B", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = "9";
    in_sos   = 1'b1;
    in_eos   = 1'b0;
    check("R11", "ready low in verdict cycle", in_ready, 1'b0);
    check("R11", "verdict present", result_valid, 1'b1);
    put("9", 1'b1, 1'b0, 1'b1);
    put("8", 1'b0, 1'b0, 1'b0);
    put("7", 1'b0, 1'b0, 1'b0);
    put("6", 1'b0, 1'b0, 1'b0);
    put(" ", 1'b0, 1'b0, 1'b0);
    put("K", 1'b0, 1'b0, 1'b0);
    put("L", 1'b0, 1'b1, 1'b0);
    idle();
    check("R11", "held beat was taken once", result_accept, 1'b1);

    // R12: accept low outside verdict
    idle();
    check("R12", "accept quiet", result_accept, 1'b0);

    repeat (3) idle();
    finish_run();
  end
endmodule